// File: doc/BRIEF.md
# Context-Switch Microcode Sequencer

This block runs a short microprogram that saves or restores an engine's context. The host fills a 256-word instruction store through an upload port: it rewinds the write index to zero, then writes the words back to back, and the index steps forward after each write. A start strobe then runs the program from word 0 until an end opcode returns the sequencer to idle.

Each 24-bit instruction has its class in bits 23:20. The classes are register transfer, scratch load, branch, wait, flag set and a miscellaneous group. Branch, wait and set all use one space of 128 flags. Some flags are live engine inputs: busy status and the automatic save and load requests. Two flags latch pulsed user requests. One flag always reads true. The remaining flags are plain storage.

A transfer moves a run of consecutive register words between the register-file port and the context-memory port. Flag 0 picks the direction at run time. The context-memory position is a pointer that a scratch load sets and that steps forward by one for every word the memory accepts. The miscellaneous group issues one-cycle control pulses and holds the end opcode.

Top module: `ctxseq_top`

## Requirements
- R1: Words written on `up_wr` after an `up_rewind` pulse fill the store from index 0 in ascending order, and a started program fetches its first instruction from index 0.
- R2: `seq_busy` is 0 after reset and rises in the cycle after `start` is sampled. The end opcode (class 0x6, bits 7:0 = 0x0E) returns `seq_busy` to 0. While `seq_busy` is 0 there is no memory or register activity.
- R3: Branch (class 0x4) jumps to the address in bits 15:8 when the flag indexed by bits 6:0 differs from bit 7. Otherwise it falls through to the next word.
- R4: Wait (class 0x5) holds the program counter until the flag indexed by bits 6:0 equals bit 7.
- R5: Set (class 0x7) writes bit 7 into the flag indexed by bits 6:0. Flags 5 and 6 are also set by `user_save_req` and `user_load_req`. Flags 96, 100 and 101 read `eng_busy`, `auto_save_req` and `auto_load_req`. Flag 104 reads 1, and writes to it have no effect.
- R6: A transfer (class 0x1, count in bits 19:14, register address in bits 13:0) with flag 0 = 1 copies registers base..base+count-1 into context memory at consecutive positions, with `cm_we` = 1.
- R7: With flag 0 = 0, a transfer reads context memory at consecutive positions and writes the words into registers base..base+count-1.
- R8: A transfer with count 0 moves nothing and leaves the position unchanged (default setting of `CNT_PLUS_ONE` = 0).
- R9: Scratch load (class 0x2) sets the context-memory position to bits 19:0.
- R10: Miscellaneous codes in bits 7:0 issue one-cycle pulses: 0x07 on `pulse_swap`, 0x09 on `pulse_current`, 0x0A on `pulse_ptr`. At most one pulse is active in any cycle.
- R11: `cm_valid` and `cm_addr` stay stable while `cm_ready` is low, and the position steps forward by one for each accepted word.
- R12: Classes 0x0, 0x3, 0x8 and the other unlisted classes, as well as unlisted miscellaneous codes, take one cycle and change no state other than the program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_rewind | input | 1 | Sets the upload index to 0 |
| up_wr | input | 1 | Writes `up_data` at the upload index, then increments the index |
| up_data | input | 24 | Instruction word to upload |
| start | input | 1 | Starts the program at word 0 when idle |
| eng_busy | input | 1 | Engine busy status (flag 96) |
| auto_save_req | input | 1 | Automatic save pending (flag 100) |
| auto_load_req | input | 1 | Automatic load pending (flag 101) |
| user_save_req | input | 1 | Pulse that sets flag 5 |
| user_load_req | input | 1 | Pulse that sets flag 6 |
| rf_addr | output | 14 | Register-file word address |
| rf_we | output | 1 | Register-file write strobe |
| rf_wdata | output | 32 | Register-file write data |
| rf_rdata | input | 32 | Register-file read data (combinational) |
| cm_valid | output | 1 | Context-memory request valid |
| cm_we | output | 1 | Context-memory write (1) or read (0) |
| cm_addr | output | 20 | Context-memory word position |
| cm_wdata | output | 32 | Context-memory write data |
| cm_rdata | input | 32 | Context-memory read data |
| cm_ready | input | 1 | Context-memory accepts the request |
| pulse_swap | output | 1 | Next-context-to-swap pulse |
| pulse_current | output | 1 | Next-context-to-current pulse |
| pulse_ptr | output | 1 | Set-context-pointer pulse |
| seq_busy | output | 1 | Sequencer is running |
| flag_dir | output | 1 | Flag 0: transfer direction (1 = save) |
| flag_usave | output | 1 | Flag 5: user save pending |
| flag_uload | output | 1 | Flag 6: user load pending |

## Verification
A single dispatch program runs under six combinations of the request flags. These cover a user save, a user load, an automatic save, and no request. In the two runs with no request, no transfer may occur and the direction flag must keep its previous value. A save followed by a load with the registers cleared in between shows that the data makes a full round trip. The memory stalls on alternate cycles during one save and one load, which separates correct handshake holding from dropped or repeated words. Directed programs then target the cases one at a time: a zero-count transfer next to a one-word transfer, nop encodings that resemble a scratch load, a write to the always-true flag, and a wait held open by the busy input.

// File: rtl/ctxseq_pkg.sv
package ctxseq_pkg;
  localparam int IW = 24;

  // opcode classes, bits 23:20
  localparam logic [3:0] CLS_XFER    = 4'h1;
  localparam logic [3:0] CLS_SCRATCH = 4'h2;
  localparam logic [3:0] CLS_BRANCH  = 4'h4;
  localparam logic [3:0] CLS_WAIT    = 4'h5;
  localparam logic [3:0] CLS_MISC    = 4'h6;
  localparam logic [3:0] CLS_SETF    = 4'h7;

  // miscellaneous codes, bits 7:0
  localparam logic [7:0] MISC_SWAP = 8'h07;
  localparam logic [7:0] MISC_CUR  = 8'h09;
  localparam logic [7:0] MISC_PTR  = 8'h0A;
  localparam logic [7:0] MISC_END  = 8'h0E;

  // flag indices (group*32 + bit)
  localparam int FLG_DIR   = 0;
  localparam int FLG_USAVE = 5;
  localparam int FLG_ULOAD = 6;
  localparam int FLG_BUSY  = 96;
  localparam int FLG_ASAVE = 100;
  localparam int FLG_ALOAD = 101;
  localparam int FLG_TRUE  = 104;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EXEC = 2'd1,
    ST_XFER = 2'd2
  } seq_st_e;

  function automatic logic [3:0] op_class(input logic [IW-1:0] w);
    return w[23:20];
  endfunction
endpackage

// File: rtl/ctxseq_store.sv
module ctxseq_store #(
  parameter int DEPTH = 256,
  parameter int WW    = 24,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rewind,
  input  logic          wr,
  input  logic [WW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [WW-1:0] rdata
);
  logic [WW-1:0] mem [DEPTH];
  logic [AW-1:0] widx_q, widx_d;
  logic          widx_en;

  always_comb begin
    widx_en = rewind | wr;
    widx_d  = rewind ? '0 : widx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       widx_q <= '0;
    else if (widx_en) widx_q <= widx_d;
  end

  always_ff @(posedge clk) begin
    if (wr && !rewind) mem[widx_q] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/ctxseq_flags.sv
module ctxseq_flags
  import ctxseq_pkg::*;
#(
  parameter int NFLAGS = 128,
  localparam int FIW   = $clog2(NFLAGS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [FIW-1:0] widx,
  input  logic           wval,
  input  logic [FIW-1:0] ridx,
  output logic           rval,
  input  logic           eng_busy,
  input  logic           auto_save_req,
  input  logic           auto_load_req,
  input  logic           user_save_req,
  input  logic           user_load_req,
  output logic           dir,
  output logic           usave,
  output logic           uload
);
  logic [NFLAGS-1:0] fl_q, fl_d, view;
  logic              fl_en;

  always_comb begin
    fl_d  = fl_q;
    fl_en = we | user_save_req | user_load_req;
    if (we) fl_d[widx] = wval;
    if (user_save_req) fl_d[FLG_USAVE] = 1'b1;
    if (user_load_req) fl_d[FLG_ULOAD] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     fl_q <= '0;
    else if (fl_en) fl_q <= fl_d;
  end

  // live and constant flags override storage on reads
  always_comb begin
    view            = fl_q;
    view[FLG_BUSY]  = eng_busy;
    view[FLG_ASAVE] = auto_save_req;
    view[FLG_ALOAD] = auto_load_req;
    view[FLG_TRUE]  = 1'b1;
    rval            = view[ridx];
  end

  assign dir   = fl_q[FLG_DIR];
  assign usave = fl_q[FLG_USAVE];
  assign uload = fl_q[FLG_ULOAD];
endmodule

// File: rtl/ctxseq_xfer.sv
module ctxseq_xfer #(
  parameter int DATA_W  = 32,
  parameter int RADDR_W = 14,
  parameter int POS_W   = 20,
  parameter int LEFT_W  = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic [LEFT_W-1:0]  go_cnt,
  input  logic [RADDR_W-1:0] go_base,
  input  logic               dir_save,
  input  logic               pos_ld,
  input  logic [POS_W-1:0]   pos_val,
  output logic               done,
  output logic [RADDR_W-1:0] rf_addr,
  output logic               rf_we,
  output logic [DATA_W-1:0]  rf_wdata,
  input  logic [DATA_W-1:0]  rf_rdata,
  output logic               cm_valid,
  output logic               cm_we,
  output logic [POS_W-1:0]   cm_addr,
  output logic [DATA_W-1:0]  cm_wdata,
  input  logic [DATA_W-1:0]  cm_rdata,
  input  logic               cm_ready
);
  logic               act_q, act_d;
  logic [LEFT_W-1:0]  left_q, left_d;
  logic [RADDR_W-1:0] ra_q, ra_d;
  logic [POS_W-1:0]   pos_q, pos_d;
  logic               beat, run_en, pos_en;

  always_comb begin
    beat   = act_q & cm_ready;
    done   = beat & (left_q == LEFT_W'(1));
    act_d  = act_q;
    left_d = left_q;
    ra_d   = ra_q;
    pos_d  = pos_q;
    run_en = go | beat;
    pos_en = pos_ld | beat;
    if (go) begin
      act_d  = 1'b1;
      left_d = go_cnt;
      ra_d   = go_base;
    end else if (beat) begin
      left_d = left_q - 1'b1;
      ra_d   = ra_q + 1'b1;
      if (left_q == LEFT_W'(1)) act_d = 1'b0;
    end
    if (pos_ld)    pos_d = pos_val;
    else if (beat) pos_d = pos_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      left_q <= '0;
      ra_q   <= '0;
    end else if (run_en) begin
      act_q  <= act_d;
      left_q <= left_d;
      ra_q   <= ra_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos_q <= '0;
    else if (pos_en) pos_q <= pos_d;
  end

  assign cm_valid = act_q;
  assign cm_we    = dir_save;
  assign cm_addr  = pos_q;
  assign cm_wdata = rf_rdata;
  assign rf_addr  = ra_q;
  assign rf_we    = beat & ~dir_save;
  assign rf_wdata = cm_rdata;
endmodule

// File: rtl/ctxseq_top.sv
module ctxseq_top
  import ctxseq_pkg::*;
#(
  parameter int STORE_DEPTH  = 256,
  parameter int NFLAGS       = 128,
  parameter int DATA_W       = 32,
  parameter int RADDR_W      = 14,
  parameter int POS_W        = 20,
  parameter int CNT_W        = 6,
  parameter bit CNT_PLUS_ONE = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               up_rewind,
  input  logic               up_wr,
  input  logic [IW-1:0]      up_data,
  input  logic               start,
  input  logic               eng_busy,
  input  logic               auto_save_req,
  input  logic               auto_load_req,
  input  logic               user_save_req,
  input  logic               user_load_req,
  output logic [RADDR_W-1:0] rf_addr,
  output logic               rf_we,
  output logic [DATA_W-1:0]  rf_wdata,
  input  logic [DATA_W-1:0]  rf_rdata,
  output logic               cm_valid,
  output logic               cm_we,
  output logic [POS_W-1:0]   cm_addr,
  output logic [DATA_W-1:0]  cm_wdata,
  input  logic [DATA_W-1:0]  cm_rdata,
  input  logic               cm_ready,
  output logic               pulse_swap,
  output logic               pulse_current,
  output logic               pulse_ptr,
  output logic               seq_busy,
  output logic               flag_dir,
  output logic               flag_usave,
  output logic               flag_uload
);
  localparam int PCW    = $clog2(STORE_DEPTH);
  localparam int FIW    = $clog2(NFLAGS);
  localparam int LEFT_W = CNT_W + 1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  seq_st_e         st_q, st_d;
  logic [PCW-1:0]  pc_q, pc_d;
  logic            pc_en;
  logic [IW-1:0]   instr;
  logic [3:0]      cls;
  logic            fl_rd, fl_we;
  logic            xf_go, xf_done, pos_ld;
  logic [LEFT_W-1:0] eff_cnt;

  ctxseq_store #(.DEPTH(STORE_DEPTH), .WW(IW)) u_store (
    .clk(clk), .rst_n(rst_i_n), .rewind(up_rewind), .wr(up_wr),
    .wdata(up_data), .raddr(pc_q), .rdata(instr)
  );

  ctxseq_flags #(.NFLAGS(NFLAGS)) u_flags (
    .clk(clk), .rst_n(rst_i_n), .we(fl_we), .widx(instr[FIW-1:0]),
    .wval(instr[7]), .ridx(instr[FIW-1:0]), .rval(fl_rd),
    .eng_busy(eng_busy), .auto_save_req(auto_save_req),
    .auto_load_req(auto_load_req), .user_save_req(user_save_req),
    .user_load_req(user_load_req), .dir(flag_dir), .usave(flag_usave),
    .uload(flag_uload)
  );

  // count interpretation chosen by parameter
  generate
    if (CNT_PLUS_ONE) begin : g_cnt_plus
      assign eff_cnt = {1'b0, instr[14 +: CNT_W]} + 1'b1;
    end else begin : g_cnt_plain
      assign eff_cnt = {1'b0, instr[14 +: CNT_W]};
    end
  endgenerate

  ctxseq_xfer #(
    .DATA_W(DATA_W), .RADDR_W(RADDR_W), .POS_W(POS_W), .LEFT_W(LEFT_W)
  ) u_xfer (
    .clk(clk), .rst_n(rst_i_n), .go(xf_go), .go_cnt(eff_cnt),
    .go_base(instr[RADDR_W-1:0]), .dir_save(flag_dir), .pos_ld(pos_ld),
    .pos_val(instr[POS_W-1:0]), .done(xf_done),
    .rf_addr(rf_addr), .rf_we(rf_we), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata),
    .cm_valid(cm_valid), .cm_we(cm_we), .cm_addr(cm_addr), .cm_wdata(cm_wdata),
    .cm_rdata(cm_rdata), .cm_ready(cm_ready)
  );

  assign cls = op_class(instr);

  always_comb begin
    st_d          = st_q;
    pc_d          = pc_q;
    fl_we         = 1'b0;
    xf_go         = 1'b0;
    pos_ld        = 1'b0;
    pulse_swap    = 1'b0;
    pulse_current = 1'b0;
    pulse_ptr     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d = ST_EXEC;
          pc_d = '0;
        end
      end
      ST_EXEC: begin
        pc_d = pc_q + 1'b1;
        case (cls)
          CLS_XFER: begin
            if (eff_cnt != '0) begin
              xf_go = 1'b1;
              st_d  = ST_XFER;
              pc_d  = pc_q;
            end
          end
          CLS_SCRATCH: pos_ld = 1'b1;
          CLS_BRANCH: begin
            if (fl_rd ^ instr[7]) pc_d = instr[8 +: PCW];
          end
          CLS_WAIT: begin
            if (fl_rd != instr[7]) pc_d = pc_q;
          end
          CLS_SETF: fl_we = 1'b1;
          CLS_MISC: begin
            case (instr[7:0])
              MISC_SWAP: pulse_swap    = 1'b1;
              MISC_CUR:  pulse_current = 1'b1;
              MISC_PTR:  pulse_ptr     = 1'b1;
              MISC_END:  st_d          = ST_IDLE;
              default:   ;
            endcase
          end
          default: ;
        endcase
      end
      ST_XFER: begin
        if (xf_done) begin
          pc_d = pc_q + 1'b1;
          st_d = ST_EXEC;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign pc_en = (st_q != ST_IDLE) | start;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) st_q <= ST_IDLE;
    else          st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)   pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  assign seq_busy = (st_q != ST_IDLE);
endmodule

// File: rtl/ctxseq_chk.sv
module ctxseq_chk #(
  parameter int POS_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cm_valid,
  input logic             cm_ready,
  input logic             cm_we,
  input logic [POS_W-1:0] cm_addr,
  input logic             rf_we,
  input logic             flag_dir,
  input logic             pulse_swap,
  input logic             pulse_current,
  input logic             pulse_ptr,
  input logic             seq_busy
);
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_valid && !cm_ready) |=> (cm_valid && $stable(cm_addr)));

  a_r11_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_valid && cm_ready) |=> (!cm_valid || cm_addr == $past(cm_addr) + 1'b1));

  a_r6_save_dir: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid |-> (cm_we == flag_dir));

  a_r7_load_write: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (!flag_dir && cm_valid && cm_ready));

  a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pulse_swap, pulse_current, pulse_ptr}));

  a_r2_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_busy |-> (!cm_valid && !rf_we && !pulse_swap && !pulse_current && !pulse_ptr));
endmodule

bind ctxseq_top ctxseq_chk #(.POS_W(POS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cm_valid(cm_valid), .cm_ready(cm_ready),
  .cm_we(cm_we), .cm_addr(cm_addr), .rf_we(rf_we), .flag_dir(flag_dir),
  .pulse_swap(pulse_swap), .pulse_current(pulse_current),
  .pulse_ptr(pulse_ptr), .seq_busy(seq_busy)
);

// File: tb/ctxseq_top_test.sv
module ctxseq_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        up_rewind = 1'b0, up_wr = 1'b0;
  logic [23:0] up_data = '0;
  logic        start = 1'b0, eng_busy = 1'b0;
  logic        auto_save_req = 1'b0, auto_load_req = 1'b0;
  logic        user_save_req = 1'b0, user_load_req = 1'b0;
  logic [13:0] rf_addr;
  logic        rf_we;
  logic [31:0] rf_wdata, rf_rdata;
  logic        cm_valid, cm_we, cm_ready;
  logic [19:0] cm_addr;
  logic [31:0] cm_wdata, cm_rdata;
  logic        pulse_swap, pulse_current, pulse_ptr, seq_busy;
  logic        flag_dir, flag_usave, flag_uload;

  always #5 clk = ~clk;

  ctxseq_top uut (
    .clk(clk), .rst_n(rst_n), .up_rewind(up_rewind), .up_wr(up_wr),
    .up_data(up_data), .start(start), .eng_busy(eng_busy),
    .auto_save_req(auto_save_req), .auto_load_req(auto_load_req),
    .user_save_req(user_save_req), .user_load_req(user_load_req),
    .rf_addr(rf_addr), .rf_we(rf_we), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata),
    .cm_valid(cm_valid), .cm_we(cm_we), .cm_addr(cm_addr), .cm_wdata(cm_wdata),
    .cm_rdata(cm_rdata), .cm_ready(cm_ready), .pulse_swap(pulse_swap),
    .pulse_current(pulse_current), .pulse_ptr(pulse_ptr), .seq_busy(seq_busy),
    .flag_dir(flag_dir), .flag_usave(flag_usave), .flag_uload(flag_uload)
  );

  // bench-side register file and context memory models
  logic [31:0] rf [64];
  logic [31:0] cm [64];
  logic        poke_rf = 1'b0;
  logic [5:0]  poke_idx = '0;
  logic [31:0] poke_val = '0;
  logic        stall_mode = 1'b0, rdy_tgl = 1'b0;
  int n_cmw = 0, n_rfw = 0, n_swap = 0, n_cur = 0, n_ptr = 0, n_stall = 0, n_viol = 0;
  logic        prev_stall = 1'b0;
  logic [19:0] prev_addr = '0;

  assign cm_ready = !stall_mode || rdy_tgl;
  assign rf_rdata = rf[rf_addr[5:0]];
  assign cm_rdata = cm[cm_addr[5:0]];

  always @(posedge clk) begin
    rdy_tgl <= ~rdy_tgl;
    if (poke_rf) rf[poke_idx] <= poke_val;
    else if (rf_we) begin
      rf[rf_addr[5:0]] <= rf_wdata;
      n_rfw <= n_rfw + 1;
    end
    if (cm_valid && cm_ready && cm_we) begin
      cm[cm_addr[5:0]] <= cm_wdata;
      n_cmw <= n_cmw + 1;
    end
    if (pulse_swap)    n_swap <= n_swap + 1;
    if (pulse_current) n_cur  <= n_cur + 1;
    if (pulse_ptr)     n_ptr  <= n_ptr + 1;
    if (cm_valid && !cm_ready) n_stall <= n_stall + 1;
    if (prev_stall && (!cm_valid || cm_addr != prev_addr)) n_viol <= n_viol + 1;
    prev_stall <= cm_valid && !cm_ready;
    prev_addr  <= cm_addr;
  end

  int n_run = 0, n_fail = 0;
  localparam logic [31:0] K0 = 32'hA5A5_0001, K1 = 32'h5A5A_0002, K2 = 32'hC3C3_0003;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_tb();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  task automatic poke(input int idx, input logic [31:0] val);
    @(negedge clk);
    poke_rf = 1'b1; poke_idx = idx[5:0]; poke_val = val;
    @(negedge clk);
    poke_rf = 1'b0;
  endtask

  task automatic upload(input logic [23:0] q [$]);
    @(negedge clk);
    up_rewind = 1'b1;
    @(negedge clk);
    up_rewind = 1'b0;
    foreach (q[i]) begin
      up_wr = 1'b1; up_data = q[i];
      @(negedge clk);
    end
    up_wr = 1'b0;
  endtask

  task automatic run_prog(input string req);
    int t;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (seq_busy && t < 3000) begin
      @(negedge clk);
      t++;
    end
    chk(req, 32'(t < 3000), 32'd1);
    @(negedge clk);
  endtask

  // {stall, usave, uload, asave, -, exp_save, exp_load, exp_dir}
  localparam logic [7:0] ROWS [6] = '{8'h45, 8'h01, 8'h22, 8'h00, 8'h95, 8'hA2};

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_tb();
  end

  initial begin
    logic [23:0] prog [$];
    int s_cmw, s_rfw, s_cur, s_sw, s_ptr, s_stall, s_viol;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R2: reset state
    chk("R2 reset busy", 32'(seq_busy), 0);
    chk("R2 reset cm_valid", 32'(cm_valid), 0);
    chk("R5 reset flags", {29'd0, flag_dir, flag_usave, flag_uload}, 0);
    chk("R10 reset pulses", {29'd0, pulse_swap, pulse_current, pulse_ptr}, 0);

    for (int i = 4; i < 7; i++) poke(i, (i == 4) ? K0 : (i == 5) ? K1 : K2);

    // R1 dispatch program: branches on pending flags, save or load three regs
    prog = {24'h400764, 24'h400705, 24'h400406, 24'h400B68, 24'h500060,
            24'h700000, 24'h400868, 24'h700080, 24'h200010, 24'h10C004,
            24'h600009, 24'h700005, 24'h700006, 24'h60000E};
    upload(prog);

    for (int r = 0; r < 6; r++) begin
      logic [7:0] row;
      row = ROWS[r];
      if (row[1]) for (int i = 4; i < 7; i++) poke(i, 32'h0);
      @(negedge clk);
      stall_mode = row[7];
      auto_save_req = row[4];
      user_save_req = row[6];
      user_load_req = row[5];
      @(negedge clk);
      user_save_req = 1'b0; user_load_req = 1'b0;
      s_cmw = n_cmw; s_rfw = n_rfw; s_cur = n_cur; s_stall = n_stall; s_viol = n_viol;
      run_prog("R2 program ends");
      chk("R6 save word count", 32'(n_cmw - s_cmw), row[2] ? 3 : 0);
      chk("R7 load word count", 32'(n_rfw - s_rfw), row[1] ? 3 : 0);
      chk("R3 current pulse count", 32'(n_cur - s_cur), (row[2] | row[1]) ? 1 : 0);
      chk("R5 direction flag", 32'(flag_dir), 32'(row[0]));
      chk("R5 user flags cleared", {30'd0, flag_usave, flag_uload}, 0);
      chk("R11 hold violations", 32'(n_viol - s_viol), 0);
      if (row[7]) chk("R11 stalls seen", 32'(n_stall - s_stall > 0), 1);
      if (row[2]) begin
        chk("R6 cm[16]", cm[16], K0);
        chk("R6 cm[17]", cm[17], K1);
        chk("R6 cm[18]", cm[18], K2);
      end
      if (row[1]) begin
        chk("R7 rf[4]", rf[4], K0);
        chk("R7 rf[5]", rf[5], K1);
        chk("R7 rf[6]", rf[6], K2);
      end
      stall_mode = 1'b0;
      auto_save_req = 1'b0;
    end

    // R2: busy rises the cycle after start
    prog = {24'h60000E};
    upload(prog);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 busy after start", 32'(seq_busy), 1);
    @(negedge clk);
    chk("R2 idle after end", 32'(seq_busy), 0);

    // R8: zero-count transfer moves nothing, position unchanged
    prog = {24'h700080, 24'h200020, 24'h100004, 24'h104005, 24'h60000E};
    upload(prog);
    s_cmw = n_cmw;
    run_prog("R8 program ends");
    chk("R8 one word moved", 32'(n_cmw - s_cmw), 1);
    chk("R8 position kept", cm[32], K1);

    // R10 / R12 / R9: pulses, nops that must not load the position
    prog = {24'h700080, 24'h200028, 24'h600007, 24'h800001, 24'h30000C,
            24'h60000A, 24'h000000, 24'h600009, 24'h600005, 24'h104004, 24'h60000E};
    upload(prog);
    s_cmw = n_cmw; s_rfw = n_rfw; s_sw = n_swap; s_cur = n_cur; s_ptr = n_ptr;
    run_prog("R10 program ends");
    chk("R10 swap pulse", 32'(n_swap - s_sw), 1);
    chk("R10 ptr pulse", 32'(n_ptr - s_ptr), 1);
    chk("R10 current pulse", 32'(n_cur - s_cur), 1);
    chk("R12 nop no reg writes", 32'(n_rfw - s_rfw), 0);
    chk("R12 nop no extra words", 32'(n_cmw - s_cmw), 1);
    chk("R9 scratch position kept by nops", cm[40], K0);

    // R5 / R3: write to always-true flag ignored, branch-if-clear not taken
    prog = {24'h700000, 24'h700068, 24'h4004E8, 24'h60000E, 24'h700080, 24'h60000E};
    upload(prog);
    run_prog("R5 program ends");
    chk("R5 flag104 stays true", 32'(flag_dir), 0);

    // R4: wait holds while busy
    prog = {24'h500060, 24'h600007, 24'h60000E};
    upload(prog);
    eng_busy = 1'b1;
    s_sw = n_swap;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    chk("R4 still waiting", 32'(seq_busy), 1);
    chk("R4 no pulse during wait", 32'(n_swap - s_sw), 0);
    eng_busy = 1'b0;
    repeat (5) @(negedge clk);
    chk("R4 resumed and ended", 32'(seq_busy), 0);
    chk("R4 pulse after wait", 32'(n_swap - s_sw), 1);

    finish_tb();
  end
endmodule